// File: doc/BRIEF.md
# Configuration Access Router

This block sits in front of a root-complex controller and steers each configuration access, given as a bus, device, function and register offset, to one of three places: the controller's own register space, the type-0 configuration window or the type-1 configuration window. The choice depends on how the requested bus relates to a first-bus number that software programs. Before a window access, the router writes the encoded bus/device/function into the target field of the matching address translation region. The window access therefore reaches the intended device.

Requests arrive over a valid/ready handshake. The router holds ready low from acceptance until its one-cycle response is given. Requests that name a device other than zero are refused. So are requests for a function other than zero on the first bus. A refused read completes normally with all-ones data. A refused write is flagged as an error and touches nothing downstream. The translation datapath and the link transactions themselves lie outside this block.

Top module: `cfg_access_router`

## Requirements
- R1: A request with a device number other than 0 is refused on any bus: no translation write and no target access occur. A refused read responds with data 0xFFFFFFFF and rsp_err 0. A refused write responds with rsp_err 1.
- R2: A request on the first bus with a function number other than 0 is refused in the same way as in R1.
- R3: A valid request whose bus equals the first bus goes to the local register space (tgt_sel 0) with no translation write.
- R4: A valid request on bus first+1 (compared without wrap, so a first bus of 255 has no such bus) first writes translation region 0 (xlat_region 0) and then accesses the type-0 window (tgt_sel 1).
- R5: A valid request on any other bus, including buses below the first bus, first writes translation region 1 (xlat_region 1) and then accesses the type-1 window (tgt_sel 2).
- R6: tgt_addr equals the request offset with its two low bits cleared.
- R7: xlat_target carries bus in bits 31:24, device in bits 23:19 and function in bits 18:16, with bits 15:0 zero.
- R8: req_ready stays low from the acceptance cycle until the response has been given. The translation write pulses in the cycle directly before tgt_valid rises. tgt_valid and its fields stay steady until tgt_done.
- R9: The first-bus register loads first_bus_wdata when first_bus_we is high, and it resets to 0.
- R10: An accepted read responds with tgt_rdata captured at tgt_done and rsp_err 0. An accepted write responds with rsp_err 0 and data 0. rsp_valid is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| first_bus_we | input | 1 | Load strobe for the first-bus register |
| first_bus_wdata | input | 8 | New first-bus number |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Router idle and accepting |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Requested bus number |
| req_dev | input | 5 | Requested device number |
| req_func | input | 3 | Requested function number |
| req_offset | input | OFF_W | Register byte offset |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DATA_W | Read data (0 for writes) |
| rsp_err | output | 1 | Refused write |
| xlat_we | output | 1 | Translation target write strobe |
| xlat_region | output | 1 | 0 = region 0, 1 = region 1 |
| xlat_target | output | 32 | Encoded bus/device/function |
| tgt_valid | output | 1 | Target access active |
| tgt_sel | output | 2 | 0 local, 1 type-0 window, 2 type-1 window |
| tgt_write | output | 1 | Target access is a write |
| tgt_addr | output | OFF_W | Dword-aligned offset |
| tgt_wdata | output | DATA_W | Target write data |
| tgt_done | input | 1 | Target access complete |
| tgt_rdata | input | DATA_W | Target read data |

## Verification
The table drives reads and writes at first-bus values of 0, 4 and 255, with buses equal to, one above, far above and below the first bus. This separates the local path from the two windows and shows that a first bus of 255 does not wrap bus 0 into the type-0 window. Refused cases use a nonzero device on a remote bus and a nonzero function on the first bus. A nonzero function on a remote bus is accepted, which shows that the function rule applies only to the first bus. Unaligned offsets and distinct bus/device/function values expose errors in alignment and field placement. A reset taken with a nonzero first bus shows the register returning to zero.

// File: rtl/cfg_access_router.sv
`timescale 1ns/1ps
module cfg_access_router #(
  parameter int OFF_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              first_bus_we,
  input  logic [7:0]        first_bus_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [7:0]        req_bus,
  input  logic [4:0]        req_dev,
  input  logic [2:0]        req_func,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              xlat_we,
  output logic              xlat_region,
  output logic [31:0]       xlat_target,
  output logic              tgt_valid,
  output logic [1:0]        tgt_sel,
  output logic              tgt_write,
  output logic [OFF_W-1:0]  tgt_addr,
  output logic [DATA_W-1:0] tgt_wdata,
  input  logic              tgt_done,
  input  logic [DATA_W-1:0] tgt_rdata
);

  localparam logic [1:0] RT_LOCAL = 2'd0;
  localparam logic [1:0] RT_T0    = 2'd1;
  localparam logic [1:0] RT_T1    = 2'd2;
  localparam logic [1:0] RT_REJ   = 2'd3;
  localparam logic [OFF_W-1:0] ALIGN_MASK = ~OFF_W'(3);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_ACCESS, S_RESP} state_t;

  state_t            state;
  logic [7:0]        first_bus_q;
  logic              wr_q;
  logic [1:0]        route_q;
  logic [OFF_W-1:0]  off_q;
  logic [DATA_W-1:0] wdata_q;
  logic [31:0]       bdf_q;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q;

  logic       accept;
  logic       on_first;
  logic       on_next;
  logic       refuse;
  logic [1:0] route_d;

  assign accept   = req_valid && req_ready;
  assign on_first = (req_bus == first_bus_q);
  assign on_next  = ({1'b0, req_bus} == ({1'b0, first_bus_q} + 9'd1));
  assign refuse   = (req_dev != 5'd0) || (on_first && req_func != 3'd0);
  assign route_d  = refuse   ? RT_REJ   :
                    on_first ? RT_LOCAL :
                    on_next  ? RT_T0    : RT_T1;

  always_ff @(posedge clk) begin
    if (!rst_n) first_bus_q <= 8'd0;
    else if (first_bus_we) first_bus_q <= first_bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      wr_q    <= 1'b0;
      route_q <= RT_LOCAL;
      off_q   <= '0;
      wdata_q <= '0;
      bdf_q   <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          wr_q    <= req_write;
          route_q <= route_d;
          off_q   <= req_offset & ALIGN_MASK;
          wdata_q <= req_wdata;
          bdf_q   <= {req_bus, req_dev, req_func, 16'h0000};
          if (route_d == RT_REJ) begin
            rdata_q <= req_write ? '0 : '1;
            err_q   <= req_write;
            state   <= S_RESP;
          end else if (route_d == RT_LOCAL) begin
            state   <= S_ACCESS;
          end else begin
            state   <= S_SETUP;
          end
        end
        S_SETUP: state <= S_ACCESS;
        S_ACCESS: if (tgt_done) begin
          rdata_q <= wr_q ? '0 : tgt_rdata;
          err_q   <= 1'b0;
          state   <= S_RESP;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready   = (state == S_IDLE);
  assign rsp_valid   = (state == S_RESP);
  assign rsp_rdata   = rdata_q;
  assign rsp_err     = err_q && rsp_valid;
  assign xlat_we     = (state == S_SETUP);
  assign xlat_region = (route_q == RT_T1);
  assign xlat_target = bdf_q;
  assign tgt_valid   = (state == S_ACCESS);
  assign tgt_sel     = route_q;
  assign tgt_write   = wr_q;
  assign tgt_addr    = off_q;
  assign tgt_wdata   = wdata_q;

  a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r8_update_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tgt_valid) && tgt_sel != RT_LOCAL) |-> $past(xlat_we));

  a_r8_tgt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_valid && !tgt_done) |=> (tgt_valid && $stable(tgt_addr) && $stable(tgt_sel)));

  a_r4_region_then_access: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_we |=> (tgt_valid && tgt_sel == (xlat_region ? RT_T1 : RT_T0)));

  a_r6_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid |-> (tgt_addr[1:0] == 2'b00));

  a_r10_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r1_err_only_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && !$past(tgt_valid)));

endmodule

// File: tb/cfg_access_router_tb.sv
`timescale 1ns/1ps
module cfg_access_router_tb_top;
  localparam int OFF_W = 12;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fb_we = 1'b0;
  logic [7:0] fb_wd = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_bus = '0;
  logic [4:0] req_dev = '0;
  logic [2:0] req_func = '0;
  logic [OFF_W-1:0] req_offset = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, xlat_we, xlat_region, tgt_valid, tgt_write;
  logic [DW-1:0] rsp_rdata, tgt_wdata, tgt_rdata;
  logic [31:0] xlat_target;
  logic [1:0] tgt_sel;
  logic [OFF_W-1:0] tgt_addr;
  logic tgt_done;
  logic [1:0] tcnt;

  always #5 clk = ~clk;

  cfg_access_router #(.OFF_W(OFF_W), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .first_bus_we(fb_we), .first_bus_wdata(fb_wd),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func),
    .req_offset(req_offset), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .xlat_we(xlat_we), .xlat_region(xlat_region), .xlat_target(xlat_target),
    .tgt_valid(tgt_valid), .tgt_sel(tgt_sel), .tgt_write(tgt_write),
    .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata), .tgt_done(tgt_done),
    .tgt_rdata(tgt_rdata));

  assign tgt_rdata = 32'h5A000000 | {{(DW-OFF_W){1'b0}}, tgt_addr};

  always @(posedge clk) begin
    if (!rst_n) begin
      tcnt <= '0;
      tgt_done <= 1'b0;
    end else begin
      tgt_done <= 1'b0;
      if (tgt_valid && !tgt_done) begin
        tcnt <= tcnt + 2'd1;
        if (tcnt == 2'd1) begin
          tgt_done <= 1'b1;
          tcnt <= '0;
        end
      end
    end
  end

  int m_xcnt, m_rdyviol;
  logic m_xreg, m_tseen, m_order, m_twr, m_rsp, m_err, m_busy;
  logic [31:0] m_xtgt;
  logic [1:0] m_tsel;
  logic [OFF_W-1:0] m_taddr;
  logic [DW-1:0] m_twd, m_rdata;

  initial begin
    m_busy = 1'b0;
    m_rdyviol = 0;
  end

  always @(posedge clk) if (rst_n && req_valid && req_ready) m_busy <= 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (m_busy && req_ready) m_rdyviol = m_rdyviol + 1;
      if (xlat_we) begin
        m_xcnt = m_xcnt + 1;
        m_xreg = xlat_region;
        m_xtgt = xlat_target;
      end
      if (tgt_valid && !m_tseen) begin
        m_tseen = 1'b1;
        m_tsel = tgt_sel;
        m_taddr = tgt_addr;
        m_twr = tgt_write;
        m_twd = tgt_wdata;
        m_order = (m_xcnt > 0);
      end
      if (rsp_valid) begin
        m_rsp = 1'b1;
        m_err = rsp_err;
        m_rdata = rsp_rdata;
        m_busy <= 1'b0;
      end
    end
  end

  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic        wr;
    logic [7:0]  fb;
    logic [7:0]  bus;
    logic [4:0]  dev;
    logic [2:0]  fn;
    logic [11:0] off;
    logic [1:0]  route;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd0,   8'd0,   5'd0,  3'd0, 12'h010, 2'd0},
    '{1'b1, 8'd0,   8'd0,   5'd0,  3'd0, 12'h013, 2'd0},
    '{1'b0, 8'd0,   8'd1,   5'd0,  3'd3, 12'h0FE, 2'd1},
    '{1'b1, 8'd0,   8'd1,   5'd0,  3'd7, 12'h101, 2'd1},
    '{1'b0, 8'd0,   8'd5,   5'd0,  3'd2, 12'h02A, 2'd2},
    '{1'b0, 8'd0,   8'd0,   5'd1,  3'd0, 12'h004, 2'd3},
    '{1'b1, 8'd0,   8'd0,   5'd0,  3'd1, 12'h008, 2'd3},
    '{1'b0, 8'd4,   8'd4,   5'd0,  3'd0, 12'h3FF, 2'd0},
    '{1'b0, 8'd4,   8'd5,   5'd0,  3'd6, 12'h041, 2'd1},
    '{1'b1, 8'd4,   8'd3,   5'd0,  3'd0, 12'h0C2, 2'd2},
    '{1'b1, 8'd4,   8'd9,   5'd31, 3'd0, 12'h010, 2'd3},
    '{1'b0, 8'd255, 8'd255, 5'd0,  3'd0, 12'h020, 2'd0},
    '{1'b0, 8'd255, 8'd0,   5'd0,  3'd1, 12'h024, 2'd2},
    '{1'b0, 8'd4,   8'd4,   5'd0,  3'd5, 12'h030, 2'd3}
  };

  function automatic string route_tag(input vec_t v);
    case (v.route)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return (v.dev != 0) ? "R1" : "R2";
    endcase
  endfunction

  task automatic set_first(input logic [7:0] fb);
    @(negedge clk);
    fb_we = 1'b1;
    fb_wd = fb;
    @(negedge clk);
    fb_we = 1'b0;
  endtask

  task automatic run_req(input logic wr, input logic [7:0] bus, input logic [4:0] dev,
                         input logic [2:0] fn, input logic [11:0] off, input logic [31:0] wd);
    @(negedge clk);
    m_xcnt = 0; m_tseen = 0; m_rsp = 0; m_order = 0; m_xreg = 0; m_xtgt = '0;
    m_tsel = '0; m_taddr = '0; m_twr = 0; m_twd = '0; m_err = 0; m_rdata = '0;
    req_valid = 1'b1; req_write = wr; req_bus = bus; req_dev = dev;
    req_func = fn; req_offset = off; req_wdata = wd;
    do @(posedge clk); while (!req_ready);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 40 && !m_rsp; k++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R8 reset ready", {30'd0, req_ready, rsp_valid}, 32'h2);
    chk(tgt_valid === 1'b0 && xlat_we === 1'b0, "R8 reset idle outputs", {30'd0, tgt_valid, xlat_we}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tg;
      logic [11:0] ea;
      logic [31:0] wd;
      v = VECS[i];
      tg = route_tag(v);
      ea = v.off & 12'hFFC;
      wd = 32'hD00D0000 + i;
      set_first(v.fb);
      run_req(v.wr, v.bus, v.dev, v.fn, v.off, wd);
      chk(m_rsp, {tg, " response seen"}, {31'd0, m_rsp}, 32'd1);
      if (v.route == 2'd3) begin
        chk(!m_tseen && m_xcnt == 0, {tg, " refused: no downstream activity"}, {31'd0, m_tseen} + m_xcnt, 32'd0);
        if (v.wr) chk(m_err === 1'b1, {tg, " refused write err"}, {31'd0, m_err}, 32'd1);
        else chk(m_err === 1'b0 && m_rdata === 32'hFFFFFFFF, {tg, " refused read data"}, m_rdata, 32'hFFFFFFFF);
      end else begin
        chk(m_tseen && m_tsel == v.route, {tg, " target select"}, {30'd0, m_tsel}, {30'd0, v.route});
        chk(m_xcnt == ((v.route == 2'd0) ? 0 : 1), {tg, " translation writes"}, m_xcnt, (v.route == 2'd0) ? 0 : 1);
        if (v.route != 2'd0) begin
          chk(m_xreg == (v.route == 2'd2), {tg, " region"}, {31'd0, m_xreg}, {31'd0, v.route == 2'd2});
          chk(m_xtgt == {v.bus, v.dev, v.fn, 16'h0}, "R7 encoded target", m_xtgt, {v.bus, v.dev, v.fn, 16'h0});
          chk(m_order, "R8 update before access", {31'd0, m_order}, 32'd1);
        end
        chk(m_taddr == ea, "R6 aligned offset", {20'd0, m_taddr}, {20'd0, ea});
        chk(m_twr == v.wr, "R10 access direction", {31'd0, m_twr}, {31'd0, v.wr});
        if (v.wr) begin
          chk(m_twd == wd, "R10 write data", m_twd, wd);
          chk(m_err === 1'b0 && m_rdata === 32'd0, "R10 write response", {31'd0, m_err}, 32'd0);
        end else begin
          chk(m_err === 1'b0 && m_rdata === (32'h5A000000 | {20'd0, ea}), "R10 read data", m_rdata, 32'h5A000000 | {20'd0, ea});
        end
      end
    end

    set_first(8'd7);
    run_req(1'b0, 8'd8, 5'd0, 3'd0, 12'h010, 32'h0);
    chk(m_tseen && m_tsel == 2'd1, "R9 programmed first bus 7", {30'd0, m_tsel}, 32'd1);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    run_req(1'b0, 8'd0, 5'd0, 3'd0, 12'h010, 32'h0);
    chk(m_tseen && m_tsel == 2'd0 && m_xcnt == 0, "R9 first bus reset to 0", {30'd0, m_tsel}, 32'd0);
    run_req(1'b0, 8'd1, 5'd0, 3'd0, 12'h010, 32'h0);
    chk(m_tseen && m_tsel == 2'd1, "R9 bus 1 after reset is type-0", {30'd0, m_tsel}, 32'd1);

    chk(m_rdyviol == 0, "R8 ready low while busy", m_rdyviol, 32'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule